// File: doc/BRIEF.md
# HDLC Frame Transmitter with Tagged Byte Queue

This block turns queued bytes into a bit-serial HDLC line signal. Bytes are written into a small on-chip queue. Each queued byte also carries two marker bits. One marker closes the packet after that byte. The other abandons the packet when that byte is reached. Because the markers travel with the bytes, several packets can sit in the queue one after another. The transmitter adds an opening flag, inserts zeros after runs of five ones, appends a CRC-16 frame check, and adds a closing flag. When the queue is empty it fills the line with either continuous ones or repeated flags.

The write side is a valid/ready stream. A byte is accepted on a clock edge where `wr_valid` and `wr_ready` are both high. While the queue is full, `wr_ready` is low and a presented byte is not taken. The writer must hold the byte until it is accepted. The two marker strobes are separate single-cycle pulses. Each one arms a marker that attaches to the next accepted byte and is then cleared. The line side is paced by `bit_en`: one output bit per strobe. `free_run` advances the output every clock instead. A raw mode sends queue bytes unframed.

Top module: `hdlc_tx_tagged`

## Requirements
- R1: After reset `tx_bit` is 1, `wr_ready` is 1 and `fifo_empty` is 1; with `tx_en` low, `tx_bit` stays 1.
- R2: The queue holds 16 bytes. When it is full `wr_ready` is 0 and a presented byte is dropped, with no effect on the frames sent.
- R3: A pulse on `tag_eop_set` or `tag_abort_set` arms a marker. The pulse may come in the write cycle or any earlier cycle. The marker attaches to the next accepted byte only and is cleared by that write.
- R4: A frame is sent in this order: the opening flag 8'h7E, the payload bytes with the least significant bit first, the 16-bit check value, and the closing flag 8'h7E. Every bit position is least significant first.
- R5: After five consecutive ones in payload or check bits, a 0 is inserted. No zero is ever inserted inside a flag, the abort pattern or mark idle.
- R6: The check value is computed over the payload bits as sent before zero insertion. It uses the reflected CCITT polynomial 16'h8408 with the register preset to 16'hFFFF. The complement of the register is sent, least significant bit first.
- R7: A byte carrying the abort marker is not sent. In its place the line carries a 0 followed by seven 1s (8'hFE, least significant bit first). No check value or closing flag follows, and the line returns to idle fill.
- R8: With an empty queue between frames, `mark_fill` = 0 sends continuous ones and `mark_fill` = 1 sends back-to-back 8'h7E flags.
- R9: Dropping `tx_en` during a frame lets the frame finish through its closing flag. The line then holds 1 and takes no bytes from the queue. Raising `tx_en` again starts the next queued frame at the very next bit slot.
- R10: `tx_bit` changes only on clock edges where `bit_en` or `free_run` is high. With `free_run` high, one bit is sent per clock.
- R11: With `transparent` = 1, queued bytes are sent least significant bit first with no flags, zero insertion, check value or markers. An empty queue sends ones, and mode changes take effect at byte boundaries.
- R12: If the queue runs empty inside a frame before a closing marker, the frame is ended with the abort pattern of R7.
- R13: Packets queued back to back are each sent with their own opening and closing flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Write byte valid |
| wr_ready | output | 1 | Queue can accept a byte (not full) |
| wr_data | input | 8 | Byte to queue |
| tag_eop_set | input | 1 | Arm the close-packet marker for the next accepted byte |
| tag_abort_set | input | 1 | Arm the abort marker for the next accepted byte |
| tx_en | input | 1 | Transmitter enable; the stop is graceful at frame end |
| mark_fill | input | 1 | Idle fill select: 0 ones, 1 flags |
| transparent | input | 1 | Raw byte serialisation mode |
| free_run | input | 1 | Advance one bit every clock |
| bit_en | input | 1 | One-cycle strobe that advances one output bit |
| tx_bit | output | 1 | Serial line output |
| fifo_empty | output | 1 | Queue holds no bytes |

## Verification
Some properties are checked on every cycle. The output is held between bit strobes. A zero always follows a run of five stuffed ones. An empty queue inside a frame always starts the abort pattern. A frame in progress always goes on to its next field whatever `tx_en` is. A halted transmitter drives 1. Markers are cleared after each accepted write, and the queue count stays within bounds. Other behaviour can only be shown by the bench scenarios, which compare whole bit streams against frames built arithmetically. These cover check-value correctness over every single-byte payload, stuffing across field edges, marker placement across packets, overflow, graceful stop and restart, flag fill, and raw mode.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  localparam int BYTE_W  = 8;
  localparam int CRC_W   = 16;
  localparam logic [BYTE_W-1:0] FLAG_OCTET  = 8'h7E;
  localparam logic [BYTE_W-1:0] ABORT_OCTET = 8'hFE;
  localparam logic [BYTE_W-1:0] MARK_OCTET  = 8'hFF;
  localparam logic [CRC_W-1:0]  CRC_POLY_R  = 16'h8408;
  localparam logic [CRC_W-1:0]  CRC_PRESET  = 16'hFFFF;

  typedef struct packed {
    logic              abort;
    logic              eop;
    logic [BYTE_W-1:0] data;
  } q_word_t;

  typedef enum logic [1:0] {
    PH_OUT   = 2'd0,
    PH_BODY  = 2'd1,
    PH_CHECK = 2'd2,
    PH_CLOSE = 2'd3
  } phase_e;
endpackage

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo
  import hdlc_tx_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              tag_eop_set,
  input  logic              tag_abort_set,
  input  logic              rd_pop,
  output q_word_t           rd_word,
  output logic              empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  q_word_t        mem [DEPTH];
  logic [AW-1:0]  wp, rp;
  logic [CW-1:0]  count;
  logic           eop_arm, abort_arm;
  logic           do_wr, do_rd;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign wr_ready = (count != CW'(DEPTH));
  assign empty    = (count == '0);
  assign do_wr    = wr_valid && wr_ready;
  assign do_rd    = rd_pop && !empty;
  assign rd_word  = mem[rp];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= '{abort: abort_arm | tag_abort_set,
                             eop:   eop_arm | tag_eop_set,
                             data:  wr_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
      eop_arm <= 1'b0; abort_arm <= 1'b0;
    end else begin
      if (do_wr) wp <= bump(wp);
      if (do_rd) rp <= bump(rp);
      case ({do_wr, do_rd})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
      if (do_wr) begin
        eop_arm   <= 1'b0;
        abort_arm <= 1'b0;
      end else begin
        eop_arm   <= eop_arm | tag_eop_set;
        abort_arm <= abort_arm | tag_abort_set;
      end
    end
  end

  // R2
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ready && !do_rd) |=> !wr_ready);
  // R3
  tag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_wr |=> (!eop_arm && !abort_arm));
endmodule

// File: rtl/hdlc_tx_crc.sv
module hdlc_tx_crc
  import hdlc_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             adv,
  input  logic             din,
  output logic [CRC_W-1:0] crc
);
  logic             fb;
  logic [CRC_W-1:0] nxt;

  assign fb  = crc[0] ^ din;
  assign nxt = {1'b0, crc[CRC_W-1:1]} ^ (fb ? CRC_POLY_R : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc <= CRC_PRESET;
    else if (init) crc <= CRC_PRESET;
    else if (adv)  crc <= nxt;
  end
endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
  import hdlc_tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en,
  input  logic             free_run,
  input  logic             tx_en,
  input  logic             mark_fill,
  input  logic             transparent,
  input  q_word_t          head,
  input  logic             empty,
  output logic             pop,
  input  logic [CRC_W-1:0] crc,
  output logic             crc_init,
  output logic             crc_adv,
  output logic             crc_din,
  output logic             tx_bit
);
  localparam int FIELD_W = CRC_W;
  localparam int CNT_W   = $clog2(FIELD_W + 1);
  localparam int RUN_MAX = 5;

  function automatic logic [FIELD_W-1:0] widen(input logic [BYTE_W-1:0] b);
    return {{(FIELD_W-BYTE_W){1'b0}}, b};
  endfunction

  logic               tick, stuff_now, boundary;
  logic [FIELD_W-1:0] shreg;
  logic [CNT_W-1:0]   cnt;
  logic               stuffing, crc_on;
  logic [2:0]         ones;
  phase_e             ph;

  logic               nf_go, nf_stuff, nf_crc, nf_pop, nf_init;
  logic [FIELD_W-1:0] nf_data;
  logic [CNT_W-1:0]   nf_len;
  phase_e             nf_ph;

  assign tick      = bit_en | free_run;
  assign stuff_now = (ones == 3'(RUN_MAX));
  assign boundary  = tick && !stuff_now && (cnt == '0);

  always_comb begin
    nf_go    = 1'b1;
    nf_data  = widen(MARK_OCTET);
    nf_len   = CNT_W'(BYTE_W);
    nf_stuff = 1'b0;
    nf_crc   = 1'b0;
    nf_pop   = 1'b0;
    nf_init  = 1'b0;
    nf_ph    = ph;
    unique case (ph)
      PH_OUT: begin
        if (!tx_en) begin
          nf_go = 1'b0;
        end else if (transparent) begin
          if (!empty) begin
            nf_data = widen(head.data);
            nf_pop  = 1'b1;
          end
        end else if (!empty) begin
          nf_data = widen(FLAG_OCTET);
          nf_init = 1'b1;
          nf_ph   = PH_BODY;
        end else if (mark_fill) begin
          nf_data = widen(FLAG_OCTET);
        end
      end
      PH_BODY: begin
        if (!empty && !head.abort) begin
          nf_data  = widen(head.data);
          nf_stuff = 1'b1;
          nf_crc   = 1'b1;
          nf_pop   = 1'b1;
          nf_ph    = head.eop ? PH_CHECK : PH_BODY;
        end else begin
          nf_data = widen(ABORT_OCTET);
          nf_pop  = !empty;
          nf_ph   = PH_OUT;
        end
      end
      PH_CHECK: begin
        nf_data  = ~crc;
        nf_len   = CNT_W'(CRC_W);
        nf_stuff = 1'b1;
        nf_ph    = PH_CLOSE;
      end
      PH_CLOSE: begin
        nf_data = widen(FLAG_OCTET);
        nf_ph   = PH_OUT;
      end
      default: nf_ph = PH_OUT;
    endcase
  end

  assign pop      = boundary && nf_go && nf_pop;
  assign crc_init = boundary && nf_go && nf_init;
  assign crc_adv  = tick && !stuff_now &&
                    ((cnt != '0) ? crc_on : (nf_go && nf_crc));
  assign crc_din  = (cnt != '0) ? shreg[0] : nf_data[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_bit   <= 1'b1;
      shreg    <= '0;
      cnt      <= '0;
      stuffing <= 1'b0;
      crc_on   <= 1'b0;
      ones     <= '0;
      ph       <= PH_OUT;
    end else if (tick) begin
      if (stuff_now) begin
        tx_bit <= 1'b0;
        ones   <= '0;
      end else if (cnt != '0) begin
        tx_bit <= shreg[0];
        shreg  <= {1'b0, shreg[FIELD_W-1:1]};
        cnt    <= cnt - CNT_W'(1);
        ones   <= (stuffing && shreg[0]) ? ones + 3'd1 : 3'd0;
      end else if (nf_go) begin
        tx_bit   <= nf_data[0];
        shreg    <= {1'b0, nf_data[FIELD_W-1:1]};
        cnt      <= nf_len - CNT_W'(1);
        stuffing <= nf_stuff;
        crc_on   <= nf_crc;
        ones     <= (nf_stuff && nf_data[0]) ? ones + 3'd1 : 3'd0;
        ph       <= nf_ph;
      end else begin
        tx_bit <= 1'b1;
      end
    end
  end

  // R10
  pace_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(tx_bit));
  // R5
  stuff_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && stuff_now) |=> !tx_bit);
  // R9
  halt_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && ph == PH_OUT && !tx_en) |=> tx_bit);
  // R9
  frame_continue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && ph != PH_OUT) |=> (cnt != '0));
  // R12
  underrun_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && ph == PH_BODY && empty) |=> !tx_bit);
endmodule

// File: rtl/hdlc_tx_tagged.sv
module hdlc_tx_tagged
  import hdlc_tx_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              tag_eop_set,
  input  logic              tag_abort_set,
  input  logic              tx_en,
  input  logic              mark_fill,
  input  logic              transparent,
  input  logic              free_run,
  input  logic              bit_en,
  output logic              tx_bit,
  output logic              fifo_empty
);
  q_word_t          head;
  logic             pop, empty_w;
  logic             crc_init, crc_adv, crc_din;
  logic [CRC_W-1:0] crc_val;

  hdlc_tx_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .tag_eop_set(tag_eop_set), .tag_abort_set(tag_abort_set),
    .rd_pop(pop), .rd_word(head), .empty(empty_w)
  );

  hdlc_tx_crc u_crc (
    .clk(clk), .rst_n(rst_n),
    .init(crc_init), .adv(crc_adv), .din(crc_din), .crc(crc_val)
  );

  hdlc_tx_framer u_framer (
    .clk(clk), .rst_n(rst_n),
    .bit_en(bit_en), .free_run(free_run), .tx_en(tx_en),
    .mark_fill(mark_fill), .transparent(transparent),
    .head(head), .empty(empty_w), .pop(pop),
    .crc(crc_val), .crc_init(crc_init), .crc_adv(crc_adv), .crc_din(crc_din),
    .tx_bit(tx_bit)
  );

  assign fifo_empty = empty_w;
endmodule

// File: tb/hdlc_tx_tagged_tb.sv
`timescale 1ns/1ps
module hdlc_tx_tagged_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 0, tag_eop_set = 0, tag_abort_set = 0;
  logic [7:0] wr_data = '0;
  logic tx_en = 0, mark_fill = 0, transparent = 0, free_run = 0, bit_en = 0;
  logic wr_ready, tx_bit, fifo_empty;

  always #2.5 clk = ~clk;

  hdlc_tx_tagged u_dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .tag_eop_set(tag_eop_set), .tag_abort_set(tag_abort_set),
    .tx_en(tx_en), .mark_fill(mark_fill), .transparent(transparent),
    .free_run(free_run), .bit_en(bit_en), .tx_bit(tx_bit), .fifo_empty(fifo_empty)
  );

  int n_vec = 0, n_bad = 0;
  bit use_fr = 0;
  bit exp_q[$];
  logic [7:0] byte_q[$];
  int m_ones = 0;
  logic [15:0] m_crc;

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    n_vec++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic tick();
    if (use_fr) @(negedge clk);
    else begin
      bit_en = 1'b1; @(negedge clk);
      bit_en = 1'b0; @(negedge clk);
    end
  endtask

  task automatic push(input logic [7:0] d, input bit eop, input bit ab);
    wr_valid = 1'b1; wr_data = d; tag_eop_set = eop; tag_abort_set = ab;
    @(negedge clk);
    wr_valid = 1'b0; tag_eop_set = 1'b0; tag_abort_set = 1'b0;
  endtask

  task automatic add_raw(input logic [7:0] b);
    for (int i = 0; i < 8; i++) exp_q.push_back(b[i]);
    m_ones = 0;
  endtask

  task automatic add_stf(input bit b);
    exp_q.push_back(b);
    if (b) begin
      m_ones++;
      if (m_ones == 5) begin exp_q.push_back(1'b0); m_ones = 0; end
    end else m_ones = 0;
  endtask

  task automatic crc_bit(input bit b);
    bit fb;
    fb = m_crc[0] ^ b;
    m_crc = m_crc >> 1;
    if (fb) m_crc = m_crc ^ 16'h8408;
  endtask

  task automatic add_body();
    m_crc = 16'hFFFF;
    add_raw(8'h7E);
    foreach (byte_q[k])
      for (int i = 0; i < 8; i++) begin add_stf(byte_q[k][i]); crc_bit(byte_q[k][i]); end
  endtask

  task automatic add_frame();
    logic [15:0] fcs;
    add_body();
    fcs = ~m_crc;
    for (int i = 0; i < 16; i++) add_stf(fcs[i]);
    add_raw(8'h7E);
  endtask

  task automatic push_pkt(input bit last_abort);
    foreach (byte_q[k])
      push(byte_q[k], (k == byte_q.size() - 1) && !last_abort, 1'b0);
  endtask

  task automatic capture_check(input string req, input int drop_at, output int waited);
    int mism = -1; bit a = 0, e = 0, found = 0;
    waited = 0;
    while (!found && waited < 80) begin
      tick(); waited++;
      if (tx_bit == 1'b0) found = 1;
    end
    check(found, req, "frame start seen", int'(found), 1);
    if (found) begin
      for (int i = 1; i < exp_q.size(); i++) begin
        if (i == drop_at) tx_en = 1'b0;
        tick();
        if (tx_bit !== exp_q[i] && mism < 0) begin mism = i; a = tx_bit; e = exp_q[i]; end
      end
      check(mism < 0, req, $sformatf("stream bit %0d", mism), int'(a), int'(e));
    end
    exp_q.delete(); m_ones = 0;
  endtask

  task automatic ones_check(input string req, input int n);
    int zeros = 0;
    repeat (n) begin tick(); if (!tx_bit) zeros++; end
    check(zeros == 0, req, "zero bits while idle", zeros, 0);
  endtask

  initial begin
    int w;
    logic [7:0] b;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(tx_bit == 1'b1, "R1", "tx_bit after reset", int'(tx_bit), 1);
    check(wr_ready == 1'b1, "R1", "wr_ready after reset", int'(wr_ready), 1);
    check(fifo_empty == 1'b1, "R1", "fifo_empty after reset", int'(fifo_empty), 1);
    rst_n = 1'b1;
    @(negedge clk);
    ones_check("R1", 12);

    tx_en = 1'b1;
    // R4 R6 sweep every single-byte payload
    for (int v = 0; v < 256; v++) begin
      byte_q.delete(); byte_q.push_back(8'(v));
      push_pkt(1'b0); add_frame();
      capture_check("R4_R6", -1, w);
      ones_check("R8", 4);
    end

    // R5 lengths and stuffing-heavy patterns
    for (int len = 1; len <= 8; len++)
      for (int p = 0; p < 4; p++) begin
        byte_q.delete();
        for (int k = 0; k < len; k++) begin
          case (p)
            0: b = 8'hFF;
            1: b = 8'((k * 53 + len * 7) & 255);
            2: b = 8'h7E;
            default: b = k[0] ? 8'hF8 : 8'h1F;
          endcase
          byte_q.push_back(b);
        end
        push_pkt(1'b0); add_frame();
        capture_check("R5", -1, w);
        ones_check("R5", 4);
      end

    // R3 and R13: armed marker before write, then two queued packets
    tag_eop_set = 1'b1; @(negedge clk); tag_eop_set = 1'b0; @(negedge clk);
    push(8'h11, 1'b0, 1'b0);
    push(8'h22, 1'b0, 1'b0);
    push(8'h33, 1'b1, 1'b0);
    byte_q.delete(); byte_q.push_back(8'h11); add_frame();
    byte_q.delete(); byte_q.push_back(8'h22); byte_q.push_back(8'h33); add_frame();
    capture_check("R3_R13", -1, w);
    ones_check("R13", 8);

    // R7 abort tag
    push(8'h5A, 1'b0, 1'b0);
    push(8'h99, 1'b0, 1'b1);
    byte_q.delete(); byte_q.push_back(8'h5A); add_body(); add_raw(8'hFE);
    capture_check("R7", -1, w);
    ones_check("R7", 16);
    check(fifo_empty == 1'b1, "R7", "aborted byte consumed", int'(fifo_empty), 1);
    push(8'hF8, 1'b0, 1'b0);
    push(8'hFF, 1'b0, 1'b1);
    byte_q.delete(); byte_q.push_back(8'hF8); add_body(); add_raw(8'hFE);
    capture_check("R7", -1, w);
    ones_check("R7", 8);

    // R12 underrun
    push(8'h0F, 1'b0, 1'b0);
    byte_q.delete(); byte_q.push_back(8'h0F); add_body(); add_raw(8'hFE);
    capture_check("R12", -1, w);
    ones_check("R12", 12);

    // R2 overflow
    byte_q.delete();
    for (int k = 0; k < 16; k++) byte_q.push_back(8'((k * 29 + 3) & 255));
    push_pkt(1'b0);
    check(wr_ready == 1'b0, "R2", "wr_ready when full", int'(wr_ready), 0);
    push(8'hAA, 1'b0, 1'b0);
    add_frame();
    capture_check("R2", -1, w);
    ones_check("R2", 16);
    check(fifo_empty == 1'b1, "R2", "dropped byte absent", int'(fifo_empty), 1);

    // R8 flag fill
    mark_fill = 1'b1;
    begin
      int mism = -1, k = 0; bit found = 0;
      while (!found && k < 20) begin tick(); k++; if (!tx_bit) found = 1; end
      check(found, "R8", "fill flag seen", int'(found), 1);
      for (int i = 1; i < 32; i++) begin
        b = 8'h7E;
        tick();
        if (tx_bit !== b[i % 8] && mism < 0) mism = i;
      end
      check(mism < 0, "R8", "flag fill bit", mism, -1);
    end
    mark_fill = 1'b0;
    repeat (10) tick();
    ones_check("R8", 16);

    // R10 pacing then free run
    push(8'h6B, 1'b1, 1'b0);
    begin
      int moves = 0;
      repeat (30) begin @(negedge clk); if (!tx_bit) moves++; end
      check(moves == 0, "R10", "output moved without strobe", moves, 0);
      check(fifo_empty == 1'b0, "R10", "byte held without strobe", int'(fifo_empty), 0);
    end
    free_run = 1'b1; use_fr = 1'b1;
    byte_q.delete(); byte_q.push_back(8'h6B); add_frame();
    capture_check("R10", -1, w);
    ones_check("R10", 8);
    free_run = 1'b0; use_fr = 1'b0;
    @(negedge clk);

    // R9 graceful stop and immediate restart
    byte_q.delete();
    byte_q.push_back(8'hC1); byte_q.push_back(8'h3F); byte_q.push_back(8'h80);
    push_pkt(1'b0); add_frame();
    capture_check("R9", 14, w);
    ones_check("R9", 16);
    push(8'hC3, 1'b1, 1'b0);
    ones_check("R9", 40);
    check(fifo_empty == 1'b0, "R9", "halted left byte queued", int'(fifo_empty), 0);
    tx_en = 1'b1;
    byte_q.delete(); byte_q.push_back(8'hC3); add_frame();
    capture_check("R9", -1, w);
    check(w == 1, "R9", "slots until restart", w, 1);
    ones_check("R9", 8);

    // R11 transparent
    transparent = 1'b1;
    ones_check("R11", 10);
    push(8'h3C, 1'b0, 1'b0);
    push(8'hFF, 1'b0, 1'b0);
    push(8'h81, 1'b0, 1'b0);
    add_raw(8'h3C); add_raw(8'hFF); add_raw(8'h81);
    capture_check("R11", -1, w);
    ones_check("R11", 24);
    transparent = 1'b0;

    finish_run();
  end
endmodule